// File: doc/BRIEF.md
# Hamming ECC syndrome corrector

This block checks one 256-byte chunk of flash data after the chunk has been moved into a local buffer. It takes two 32-bit ECC words: the one kept alongside the data and the one calculated from the data as it arrived. Their XOR is the syndrome. The block counts the set bits of the syndrome in a short pipelined adder tree and classifies the chunk as clean, corrected or uncorrectable. The result appears a fixed three cycles after the check is presented.

The ECC is an interleaved line/column parity code. For a single flipped data bit, the odd-numbered syndrome bits spell out the failing location. When the block finds such an error, it reads the failing byte from the chunk buffer and writes it back with the decoded bit inverted. A syndrome with a single set bit points at damage in the ECC word itself, so the data is left alone. A stored ECC word of all ones marks a chunk from an erased page, and that chunk is passed as clean without any check. Two running counters total the corrected and the failed chunks. A page of 512 bytes needs two checks and a page of 2048 bytes needs eight; a new check may be presented on every cycle.

Top module: `eccFixTop`

## Requirements
- R1: After reset, statusValid, bufRdEn and bufWrEn are low and both counters read zero.
- R2: A check presented with chkValid high in one cycle produces statusValid high for exactly one cycle, three rising edges later. Checks may be issued back to back, and each one yields its own status. The status codes are 0 for clean, 1 for corrected and 2 for uncorrectable.
- R3: Syndrome bits 22 to 31 are ignored. If bits 0 to 21 of the syndrome are all zero, the status is clean and the buffer is not accessed.
- R4: If exactly 11 of syndrome bits 0 to 21 are set, the status is corrected. The byte index is taken from syndrome bits 7, 9, 11, 13, 15, 17, 19, 21, with bit 7 as the least significant bit. The bit index is taken from bits 1, 3, 5, with bit 1 as the least significant bit.
- R5: A correction is one read-modify-write. bufRdEn is high in the same cycle as statusValid, at the decoded byte address. In the next cycle, bufWrEn is high at the same address, and the write data is the read byte with only the decoded bit inverted.
- R6: If exactly one of syndrome bits 0 to 21 is set, the status is corrected and the buffer is not accessed.
- R7: Any other nonzero count of set bits among syndrome bits 0 to 21 gives the status uncorrectable, and the buffer is not accessed.
- R8: When storedEcc is 32'hFFFFFFFF, the status is clean and the buffer is not accessed, whatever calcEcc holds.
- R9: correctedCount rises by one for each corrected status and failedCount rises by one for each uncorrectable status. Both counters change on the same edge that raises statusValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chkValid | input | 1 | Presents one chunk check |
| storedEcc | input | 32 | ECC word read back with the chunk |
| calcEcc | input | 32 | ECC word calculated over the received chunk |
| statusValid | output | 1 | Status strobe, three cycles after chkValid |
| status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| correctedCount | output | 16 | Running total of corrected chunks |
| failedCount | output | 16 | Running total of uncorrectable chunks |
| bufRdEn | output | 1 | Buffer read strobe (data returns next cycle) |
| bufRdAddr | output | 8 | Buffer read byte address |
| bufRdData | input | 8 | Byte returned by the buffer read |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrAddr | output | 8 | Buffer write byte address |
| bufWrData | output | 8 | Repaired byte |

## Verification
The hardest situation to reach is two corrections on consecutive cycles. The write for the first correction then happens in the same cycle as the read for the second, so the pending write address and bit mask must survive while the second address is loaded. The bench issues two single-bit error syndromes for different bytes on adjacent cycles and then compares the whole buffer with its own model. Before that, it sweeps every byte and bit position. Each syndrome is built arithmetically from the parity-pair rule, so every decode path is exercised.

// File: rtl/eccFixPkg.sv
package eccFixPkg;
  localparam int SYN_BITS    = 22;
  localparam int BYTE_IDX_W  = 8;
  localparam int BIT_IDX_W   = 3;
  localparam int ONES_W      = $clog2(SYN_BITS + 1);
  localparam int SINGLE_ONES = SYN_BITS / 2;
  // syndrome position of the first byte-index bit
  localparam int BYTE_LSB    = 2 * BIT_IDX_W + 1;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_BAD   = 2'd2
  } chkStatus_e;

  typedef struct packed {
    logic loadAddr;
    logic incFixed;
    logic incBad;
  } dpStrobe_t;
endpackage

// File: rtl/eccFixDatapath.sv
module eccFixDatapath
  import eccFixPkg::*;
#(
  parameter int ECC_W   = 32,
  parameter int GROUP_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  chkValid,
  input  logic [ECC_W-1:0]      storedEcc,
  input  logic [ECC_W-1:0]      calcEcc,
  input  dpStrobe_t             strobe,
  input  logic                  wrPending,
  output logic [ONES_W-1:0]     onesCount,
  output logic                  erasedHit,
  output logic [BYTE_IDX_W-1:0] bufRdAddr,
  output logic [BYTE_IDX_W-1:0] bufWrAddr,
  input  logic [7:0]            bufRdData,
  output logic [7:0]            bufWrData,
  output logic [CNT_W-1:0]      correctedCount,
  output logic [CNT_W-1:0]      failedCount
);
  localparam int NUM_GROUPS = (SYN_BITS + GROUP_W - 1) / GROUP_W;
  localparam int PAD_W      = NUM_GROUPS * GROUP_W;
  localparam int GCNT_W     = $clog2(GROUP_W + 1);

  logic [ECC_W-1:0] synFull;
  logic [PAD_W-1:0] syn1, syn2;
  logic             erased1, erased2;
  logic [GCNT_W-1:0] grpCntQ [NUM_GROUPS];

  assign synFull = storedEcc ^ calcEcc;

  // stage 1: syndrome capture, upper bits dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syn1    <= '0;
      erased1 <= 1'b0;
    end else if (chkValid) begin
      syn1    <= PAD_W'(synFull[SYN_BITS-1:0]);
      erased1 <= &storedEcc;
    end
  end

  // stage 2: per-group population counts
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    logic [GCNT_W-1:0] grpCnt;
    always_comb begin
      grpCnt = '0;
      for (int b = 0; b < GROUP_W; b++)
        grpCnt = grpCnt + GCNT_W'(syn1[g*GROUP_W + b]);
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) grpCntQ[g] <= '0;
      else       grpCntQ[g] <= grpCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syn2    <= '0;
      erased2 <= 1'b0;
    end else begin
      syn2    <= syn1;
      erased2 <= erased1;
    end
  end

  // final adder of the tree, consumed by the control
  always_comb begin
    onesCount = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      onesCount = onesCount + ONES_W'(grpCntQ[g]);
  end
  assign erasedHit = erased2;

  // location decode from the odd syndrome bits
  logic [BYTE_IDX_W-1:0] byteIdx;
  logic [BIT_IDX_W-1:0]  bitIdx;
  always_comb begin
    for (int k = 0; k < BIT_IDX_W; k++)  bitIdx[k]  = syn2[2*k + 1];
    for (int k = 0; k < BYTE_IDX_W; k++) byteIdx[k] = syn2[BYTE_LSB + 2*k];
  end

  logic [BYTE_IDX_W-1:0] rdAddrQ, wrAddrQ;
  logic [BIT_IDX_W-1:0]  rdBitQ, wrBitQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddrQ <= '0;
      rdBitQ  <= '0;
      wrAddrQ <= '0;
      wrBitQ  <= '0;
    end else begin
      if (strobe.loadAddr) begin
        rdAddrQ <= byteIdx;
        rdBitQ  <= bitIdx;
      end
      if (wrPending) begin
        wrAddrQ <= rdAddrQ;
        wrBitQ  <= rdBitQ;
      end
    end
  end

  assign bufRdAddr = rdAddrQ;
  assign bufWrAddr = wrAddrQ;
  assign bufWrData = bufRdData ^ (8'd1 << wrBitQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      correctedCount <= '0;
      failedCount    <= '0;
    end else begin
      if (strobe.incFixed) correctedCount <= correctedCount + 1'b1;
      if (strobe.incBad)   failedCount    <= failedCount + 1'b1;
    end
  end
endmodule

// File: rtl/eccFixCtrl.sv
module eccFixCtrl
  import eccFixPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chkValid,
  input  logic [ONES_W-1:0] onesCount,
  input  logic              erasedHit,
  output dpStrobe_t         strobe,
  output logic              wrPending,
  output logic              statusValid,
  output logic [1:0]        status,
  output logic              bufRdEn,
  output logic              bufWrEn
);
  logic       v1, v2;
  chkStatus_e verdict;
  logic       needRmw;

  always_comb begin
    needRmw = 1'b0;
    if (erasedHit || onesCount == '0) begin
      verdict = ST_CLEAN;
    end else if (onesCount == ONES_W'(SINGLE_ONES)) begin
      verdict = ST_FIXED;
      needRmw = 1'b1;
    end else if (onesCount == ONES_W'(1)) begin
      verdict = ST_FIXED;
    end else begin
      verdict = ST_BAD;
    end
  end

  always_comb begin
    strobe.loadAddr = v2 && needRmw;
    strobe.incFixed = v2 && (verdict == ST_FIXED);
    strobe.incBad   = v2 && (verdict == ST_BAD);
  end

  assign wrPending = bufRdEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1          <= 1'b0;
      v2          <= 1'b0;
      statusValid <= 1'b0;
      status      <= ST_CLEAN;
      bufRdEn     <= 1'b0;
      bufWrEn     <= 1'b0;
    end else begin
      v1          <= chkValid;
      v2          <= v1;
      statusValid <= v2;
      if (v2) status <= verdict;
      bufRdEn     <= v2 && needRmw;
      bufWrEn     <= bufRdEn;
    end
  end
endmodule

// File: rtl/eccFixTop.sv
module eccFixTop
  import eccFixPkg::*;
#(
  parameter int ECC_W   = 32,
  parameter int GROUP_W = 8,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chkValid,
  input  logic [ECC_W-1:0] storedEcc,
  input  logic [ECC_W-1:0] calcEcc,
  output logic             statusValid,
  output logic [1:0]       status,
  output logic [CNT_W-1:0] correctedCount,
  output logic [CNT_W-1:0] failedCount,
  output logic             bufRdEn,
  output logic [7:0]       bufRdAddr,
  input  logic [7:0]       bufRdData,
  output logic             bufWrEn,
  output logic [7:0]       bufWrAddr,
  output logic [7:0]       bufWrData
);
  dpStrobe_t         strobe;
  logic              wrPending;
  logic [ONES_W-1:0] onesCount;
  logic              erasedHit;

  eccFixCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .chkValid(chkValid),
    .onesCount(onesCount), .erasedHit(erasedHit),
    .strobe(strobe), .wrPending(wrPending),
    .statusValid(statusValid), .status(status),
    .bufRdEn(bufRdEn), .bufWrEn(bufWrEn)
  );

  eccFixDatapath #(.ECC_W(ECC_W), .GROUP_W(GROUP_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .chkValid(chkValid),
    .storedEcc(storedEcc), .calcEcc(calcEcc),
    .strobe(strobe), .wrPending(wrPending),
    .onesCount(onesCount), .erasedHit(erasedHit),
    .bufRdAddr(bufRdAddr), .bufWrAddr(bufWrAddr),
    .bufRdData(bufRdData), .bufWrData(bufWrData),
    .correctedCount(correctedCount), .failedCount(failedCount)
  );
endmodule

// File: rtl/eccFixChecker.sv
module eccFixChecker #(
  parameter int ECC_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             chkValid,
  input logic [ECC_W-1:0] storedEcc,
  input logic             statusValid,
  input logic [1:0]       status,
  input logic [CNT_W-1:0] correctedCount,
  input logic [CNT_W-1:0] failedCount,
  input logic             bufRdEn,
  input logic [7:0]       bufRdAddr,
  input logic [7:0]       bufRdData,
  input logic             bufWrEn,
  input logic [7:0]       bufWrAddr,
  input logic [7:0]       bufWrData
);
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusValid == $past(chkValid, 3));

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |=> bufWrEn && bufWrAddr == $past(bufRdAddr));

  assert_one_bit_flip_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $countones(bufWrData ^ bufRdData) == 1);

  assert_rd_only_on_fix_R7: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn |-> statusValid && status == 2'd1);

  assert_erased_clean_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(chkValid, 3) && $past(storedEcc, 3) == '1) |-> status == 2'd0 && !bufRdEn);

  assert_fix_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && status == 2'd1) |-> correctedCount == $past(correctedCount) + 1'b1);

  assert_fail_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(statusValid && status == 2'd2) |-> $stable(failedCount));
endmodule

bind eccFixTop eccFixChecker #(.ECC_W(ECC_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .chkValid(chkValid), .storedEcc(storedEcc),
  .statusValid(statusValid), .status(status),
  .correctedCount(correctedCount), .failedCount(failedCount),
  .bufRdEn(bufRdEn), .bufRdAddr(bufRdAddr), .bufRdData(bufRdData),
  .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
);

// File: tb/eccFixTop_tb.sv
module eccFixTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chkValid = 1'b0;
  logic [31:0] storedEcc = '0;
  logic [31:0] calcEcc = '0;
  logic        statusValid;
  logic [1:0]  status;
  logic [15:0] correctedCount, failedCount;
  logic        bufRdEn, bufWrEn;
  logic [7:0]  bufRdAddr, bufWrAddr, bufRdData, bufWrData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int rdSeen = 0;
  int wrSeen = 0;
  int expFixed = 0;
  int expBad = 0;
  logic [7:0] mem [256];
  logic [7:0] expMem [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  eccFixTop dut_i (
    .clk(clk), .rstN(rstN), .chkValid(chkValid),
    .storedEcc(storedEcc), .calcEcc(calcEcc),
    .statusValid(statusValid), .status(status),
    .correctedCount(correctedCount), .failedCount(failedCount),
    .bufRdEn(bufRdEn), .bufRdAddr(bufRdAddr), .bufRdData(bufRdData),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

  // chunk buffer model: synchronous read, separate write port
  always @(posedge clk) begin
    if (bufRdEn) bufRdData <= mem[bufRdAddr];
    if (bufWrEn) mem[bufWrAddr] <= bufWrData;
  end

  always @(negedge clk) begin
    if (rstN && bufRdEn) rdSeen++;
    if (rstN && bufWrEn) wrSeen++;
  end

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, MAX_CYCLES);
      finishTest();
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] synFor(int byteI, int bitI);
    logic [10:0] loc;
    logic [31:0] s;
    loc = {byteI[7:0], bitI[2:0]};
    s = '0;
    for (int k = 0; k < 11; k++)
      s[2*k + (loc[k] ? 1 : 0)] = 1'b1;
    return s;
  endfunction

  task automatic compareMem(string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expMem[i]) bad++;
    check(tag, bad, 0);
  endtask

  // fix: expected status; flipByte < 0 means no buffer access
  task automatic runCase(string tag, logic [31:0] st, logic [31:0] syn,
                         logic [1:0] expSt, int flipByte, int flipBit);
    rdSeen = 0;
    wrSeen = 0;
    @(negedge clk);
    chkValid = 1'b1;
    storedEcc = st;
    calcEcc = st ^ syn;
    @(negedge clk);
    chkValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " status"}, {statusValid, status}, {1'b1, expSt});
    if (expSt == 2'd1) expFixed++;
    if (expSt == 2'd2) expBad++;
    check({tag, " R9 counters"}, {correctedCount, failedCount},
          {expFixed[15:0], expBad[15:0]});
    repeat (4) @(negedge clk);
    check({tag, " buffer accesses"}, {rdSeen[15:0], wrSeen[15:0]},
          (flipByte >= 0) ? 32'h0001_0001 : 32'h0);
    if (flipByte >= 0) expMem[flipByte][flipBit] = ~expMem[flipByte][flipBit];
    compareMem({tag, " buffer content"});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      expMem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {statusValid, bufRdEn, bufWrEn}, 3'b000);
    check("R1 reset counters", {correctedCount, failedCount}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {statusValid, bufRdEn, bufWrEn}, 3'b000);

    // R3 zero syndrome and ignored upper bits
    runCase("R3 zero", 32'h1357_9BDF, 32'h0, 2'd0, -1, 0);
    runCase("R3 upper only", 32'h0246_8ACE, 32'hFFC0_0000, 2'd0, -1, 0);
    runCase("R3 bit22 only", 32'h0246_8ACE, 32'h0040_0000, 2'd0, -1, 0);

    // R6 single set bit: ECC word damage
    for (int b = 0; b < 22; b++)
      runCase("R6 ecc word bit", 32'h5A5A_0F0F, 32'd1 << b, 2'd1, -1, 0);
    runCase("R6 with upper noise", 32'h5A5A_0F0F, 32'hFF80_0010, 2'd1, -1, 0);

    // R7 other counts: first n bits set
    for (int n = 2; n <= 22; n++)
      if (n != 11)
        runCase("R7 uncorrectable", 32'h0F0F_3C3C, (32'd1 << n) - 1, 2'd2, -1, 0);

    // R8 erased chunk
    runCase("R8 erased zero calc", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0, -1, 0);
    runCase("R8 erased single err", 32'hFFFF_FFFF, synFor(77, 5), 2'd0, -1, 0);
    runCase("R8 erased many", 32'hFFFF_FFFF, 32'h0000_00FF, 2'd0, -1, 0);

    // R4 / R5 sweep over every byte and bit position
    for (int by = 0; by < 256; by++)
      for (int bi = 0; bi < 8; bi++)
        runCase("R4 R5 sweep", 32'h1234_5678 ^ (by * 32'h9E37),
                synFor(by, bi) | ((by & 1) ? 32'hAB00_0000 : 32'h0),
                2'd1, by, bi);

    // R2 back-to-back: bad, clean, ecc-bit, two corrections
    rdSeen = 0;
    wrSeen = 0;
    @(negedge clk);
    chkValid = 1'b1; storedEcc = 32'h0; calcEcc = 32'h0000_0003;
    @(negedge clk);
    storedEcc = 32'h1; calcEcc = 32'h1;
    @(negedge clk);
    storedEcc = 32'h0; calcEcc = 32'h0000_0100;
    @(negedge clk);
    storedEcc = 32'h0; calcEcc = synFor(3, 6);
    check("R2 first status", {statusValid, status}, 3'b110);
    @(negedge clk);
    storedEcc = 32'h0; calcEcc = synFor(200, 1);
    check("R2 second status", {statusValid, status}, 3'b100);
    @(negedge clk);
    chkValid = 1'b0;
    check("R2 third status", {statusValid, status}, 3'b101);
    @(negedge clk);
    check("R2 fourth status", {statusValid, status}, 3'b101);
    @(negedge clk);
    check("R2 fifth status", {statusValid, status}, 3'b101);
    @(negedge clk);
    check("R2 strobe drops", statusValid, 1'b0);
    expBad += 1;
    expFixed += 3;
    repeat (4) @(negedge clk);
    check("R5 back-to-back accesses", {rdSeen[15:0], wrSeen[15:0]}, 32'h0002_0002);
    expMem[3][6] = ~expMem[3][6];
    expMem[200][1] = ~expMem[200][1];
    compareMem("R5 back-to-back content");
    check("R9 final counters", {correctedCount, failedCount},
          {expFixed[15:0], expBad[15:0]});

    finishTest();
  end
endmodule